// File: doc/BRIEF.md
# Double-Buffered Prescaled Upcounting Timer

This block is the counting core of a general-purpose timer. A programmable prescaler turns the input clock into count ticks. On each tick a 16-bit counter steps up from zero to a programmable limit. When the count passes the limit it wraps back to zero and produces an overflow. Software loads the division ratio and the limit into holding registers. The holding values become active only when an update event happens, so a new setting never takes effect partway through a count period.

Update events come from two sources: a counter overflow, or a software strobe written to a command address. Two control bits adjust this behaviour. The first blocks update events entirely, but a software strobe still restarts the counting chain. The second stops software strobes from raising the sticky update flag. The interrupt request is the flag gated by an interrupt-enable bit.

Register map, written through a single-cycle write port. All writes take effect at the clock edge where `wr_en` is high:

- Address 0: control register.
  - bit 0: run
  - bit 1: update-off
  - bit 2: quiet-software
  - bit 3: interrupt enable
- Address 1: prescaler holding register.
- Address 2: limit holding register.
- Address 3: flag. Writing bit 0 as 0 clears the flag.
- Address 4: command. Writing bit 0 as 1 issues the software update strobe.

Top module: `upcnt_timer`

## Requirements
- R1: After reset, `cnt_o` is 0, `flag_o`, `irq_o` and `uev_o` are 0, the active and holding prescaler values are 0, and the active and holding limits are 16'hFFFF.
- R2: While run (address 0, bit 0) is 1, the counter steps up by one on each tick up to the active limit and then wraps to 0 (an overflow). While run is 0, the counter holds its value.
- R3: An active prescaler value P produces one count tick every P+1 clocks, so one overflow period lasts (P+1)*(L+1) clocks for limit L.
- R4: `uev_o` pulses high for one cycle at the same edge where an overflow wraps the counter, or where a write of 1 to address 4, bit 0 is accepted. `cnt_o` is 0 in every cycle where `uev_o` is high.
- R5: Values written to addresses 1 and 2 are copied into the active prescaler and limit only at an update event. The current period completes with the old values, and the new values govern counting from the next edge.
- R6: A software strobe (address 4, bit 0 = 1) resets the counter and the prescaler counter to 0 at its edge, whether or not update-off is set.
- R7: While update-off (address 0, bit 1) is 1, no update event occurs: `uev_o` stays 0, the active values are not reloaded, and the flag is not set.
- R8: While quiet-software (address 0, bit 2) is 1, a software strobe still causes an update event but leaves the flag unchanged. Overflow-driven events still set the flag.
- R9: The flag is sticky. Writing 0 to address 3, bit 0 clears it. Writing 1 there has no effect. If a set and a clear land on the same edge, the set wins.
- R10: `irq_o` equals the flag ANDed with interrupt enable (address 0, bit 3).
- R11: An overflow and a software strobe on the same edge produce a single update event, and that event sets the flag even with quiet-software at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| cnt_o | output | 16 | Current counter value |
| uev_o | output | 1 | One-cycle update event pulse |
| flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Update interrupt request |

## Verification
Every result is registered, so a write accepted at a clock edge shows on the outputs right after that edge: the counter reset, the update pulse, the flag change and a new interrupt level. A control write changes counting only from the following edge. The overflow pulse appears at the same edge where the counter wraps to zero. The bench drives inputs on falling edges and compares all four outputs with a behavioural model on every falling edge. This places each comparison half a cycle after the edge on which the result is due. Directed checks count whole periods between update pulses, then compare those counts with (P+1)*(L+1) and with the partial period that remains after a mid-period reprogramming.

// File: rtl/upt_pkg.sv
package upt_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 3'd0,
        ADR_PSC  = 3'd1,
        ADR_LIM  = 3'd2,
        ADR_FLAG = 3'd3,
        ADR_CMD  = 3'd4
    } adr_e;

    typedef struct packed {
        logic irq_en;
        logic quiet;
        logic upd_off;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic gen;
        logic flag_clr;
    } cmd_t;

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] bits);
        ctrl_t c;
        c.run     = bits[0];
        c.upd_off = bits[1];
        c.quiet   = bits[2];
        c.irq_en  = bits[3];
        return c;
    endfunction

    function automatic logic addr_hit(input logic en,
                                      input logic [ADDR_W-1:0] a,
                                      input adr_e target);
        return en && (a == target);
    endfunction

endpackage

// File: rtl/upt_regs.sv
module upt_regs
    import upt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output ctrl_t         ctrl,
    output logic [W-1:0]  psc_pre,
    output logic [W-1:0]  lim_pre,
    output cmd_t          cmd
);
    localparam logic [W-1:0] LIM_RST = {W{1'b1}};

    logic hit_ctrl, hit_psc, hit_lim, hit_flag, hit_cmd;
    logic unused_hi;

    assign hit_ctrl = addr_hit(wr_en, wr_addr, ADR_CTRL);
    assign hit_psc  = addr_hit(wr_en, wr_addr, ADR_PSC);
    assign hit_lim  = addr_hit(wr_en, wr_addr, ADR_LIM);
    assign hit_flag = addr_hit(wr_en, wr_addr, ADR_FLAG);
    assign hit_cmd  = addr_hit(wr_en, wr_addr, ADR_CMD);

    assign cmd.gen      = hit_cmd && wr_data[0];
    assign cmd.flag_clr = hit_flag && !wr_data[0];

    assign unused_hi = ^wr_data[W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            psc_pre <= '0;
            lim_pre <= LIM_RST;
        end else begin
            if (hit_ctrl) ctrl    <= unpack_ctrl(wr_data[CTRL_W-1:0]);
            if (hit_psc)  psc_pre <= wr_data;
            if (hit_lim)  lim_pre <= wr_data;
        end
    end
endmodule

// File: rtl/upt_prescaler.sv
module upt_prescaler #(
    parameter int W = upt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         gen,
    input  logic         upd,
    input  logic [W-1:0] psc_pre,
    output logic         tick
);
    logic [W-1:0] pc;
    logic [W-1:0] psc_act;

    assign tick = run && (pc == psc_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            psc_act <= '0;
        end else begin
            if (gen || tick) pc <= '0;
            else if (run)    pc <= pc + 1'b1;
            if (upd) psc_act <= psc_pre;
        end
    end
endmodule

// File: rtl/upt_counter.sv
module upt_counter #(
    parameter int W = upt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         gen,
    input  logic         upd,
    input  logic [W-1:0] lim_pre,
    output logic [W-1:0] cnt,
    output logic [W-1:0] lim_act,
    output logic         ovf
);
    localparam logic [W-1:0] LIM_RST = {W{1'b1}};

    logic at_limit;

    assign at_limit = (cnt == lim_act);
    assign ovf      = tick && at_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            lim_act <= LIM_RST;
        end else begin
            if (gen || ovf) cnt <= '0;
            else if (tick)  cnt <= cnt + 1'b1;
            if (upd) lim_act <= lim_pre;
        end
    end
endmodule

// File: rtl/upt_update.sv
module upt_update
    import upt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ovf,
    input  cmd_t  cmd,
    input  ctrl_t ctrl,
    output logic  upd,
    output logic  uev_q,
    output logic  flag,
    output logic  irq
);
    logic flag_set;

    assign upd      = (ovf || cmd.gen) && !ctrl.upd_off;
    assign flag_set = upd && (ovf || !ctrl.quiet);
    assign irq      = flag && ctrl.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            uev_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            uev_q <= upd;
            if (flag_set)          flag <= 1'b1;
            else if (cmd.flag_clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/upcnt_timer.sv
module upcnt_timer
    import upt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  cnt_o,
    output logic          uev_o,
    output logic          flag_o,
    output logic          irq_o
);
    ctrl_t        ctrl_q;
    cmd_t         cmd;
    logic [W-1:0] psc_pre, lim_pre, lim_act;
    logic         tick, ovf, upd_evt;

    upt_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl_q), .psc_pre(psc_pre),
        .lim_pre(lim_pre), .cmd(cmd)
    );

    upt_prescaler #(.W(W)) u_psc (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .gen(cmd.gen),
        .upd(upd_evt), .psc_pre(psc_pre), .tick(tick)
    );

    upt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .gen(cmd.gen), .upd(upd_evt),
        .lim_pre(lim_pre), .cnt(cnt_o), .lim_act(lim_act), .ovf(ovf)
    );

    upt_update u_upd (
        .clk(clk), .rst(rst), .ovf(ovf), .cmd(cmd), .ctrl(ctrl_q),
        .upd(upd_evt), .uev_q(uev_o), .flag(flag_o), .irq(irq_o)
    );
endmodule

// File: rtl/upt_checker.sv
module upt_checker
    import upt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [W-1:0]  wr_data,
    input logic [W-1:0]  cnt_o,
    input logic          uev_o,
    input logic          flag_o,
    input ctrl_t         ctrl_q,
    input logic [W-1:0]  lim_act,
    input logic          upd_evt
);
    logic sw_gen, sw_clr;
    assign sw_gen = wr_en && (wr_addr == ADR_CMD) && wr_data[0];
    assign sw_clr = wr_en && (wr_addr == ADR_FLAG) && !wr_data[0];

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !sw_gen) |=> $stable(cnt_o)); // R2

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= lim_act); // R2

    AST_UEV_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        uev_o |-> (cnt_o == '0)); // R4

    AST_SHADOW_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !upd_evt |=> $stable(lim_act)); // R5

    AST_GEN_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        sw_gen |=> (cnt_o == '0)); // R6

    AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.upd_off |=> !uev_o); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !sw_clr) |=> flag_o); // R9
endmodule

bind upcnt_timer upt_checker #(.W(W), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .uev_o(uev_o), .flag_o(flag_o),
    .ctrl_q(ctrl_q), .lim_act(lim_act), .upd_evt(upd_evt)
);

// File: tb/upcnt_timer_test.sv
`timescale 1ns/1ps
module upcnt_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_o;
    logic        uev_o, flag_o, irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference state
    bit m_run, m_off, m_quiet, m_ien, m_flag, m_uev;
    int m_ppre, m_lpre, m_pact, m_lact, m_pc, m_cnt;

    always #2.5 clk = ~clk;

    upcnt_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_o(cnt_o), .uev_o(uev_o),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_off = 0; m_quiet = 0; m_ien = 0; m_flag = 0; m_uev = 0;
            m_ppre = 0; m_lpre = 65535; m_pact = 0; m_lact = 65535;
            m_pc = 0; m_cnt = 0;
        end else begin
            bit tk, ov, gn, up, clr;
            tk  = m_run && (m_pc == m_pact);
            ov  = tk && (m_cnt == m_lact);
            gn  = wr_en && wr_addr == 3'd4 && wr_data[0];
            clr = wr_en && wr_addr == 3'd3 && !wr_data[0];
            up  = (ov || gn) && !m_off;
            if (gn || ov)  m_cnt = 0;
            else if (tk)   m_cnt = m_cnt + 1;
            if (gn || tk)  m_pc = 0;
            else if (m_run) m_pc = m_pc + 1;
            if (up) begin m_pact = m_ppre; m_lact = m_lpre; end
            if (up && (ov || !m_quiet)) m_flag = 1;
            else if (clr)               m_flag = 0;
            m_uev = up;
            if (wr_en && wr_addr == 3'd0) begin
                m_run = wr_data[0]; m_off = wr_data[1];
                m_quiet = wr_data[2]; m_ien = wr_data[3];
            end
            if (wr_en && wr_addr == 3'd1) m_ppre = int'(wr_data);
            if (wr_en && wr_addr == 3'd2) m_lpre = int'(wr_data);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(int'(cnt_o) == m_cnt, "R2 count", int'(cnt_o), m_cnt);
            check(uev_o == m_uev, "R4 update pulse", int'(uev_o), int'(m_uev));
            check(flag_o == m_flag, "R9 flag", int'(flag_o), int'(m_flag));
            check(irq_o == (m_flag && m_ien), "R10 irq", int'(irq_o), int'(m_flag && m_ien));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cycles_to_uev(output int c);
        c = 0;
        do begin @(negedge clk); c++; end while (!uev_o);
    endtask

    initial begin
        int c, mx, n_uev;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check(cnt_o == 0 && !flag_o && !irq_o && !uev_o, "R1 reset outputs",
              int'({cnt_o, flag_o, irq_o, uev_o}), 0);

        wr(0, 1);                       // run, P=0 active
        idle(2);
        c = int'(cnt_o); idle(1);
        check(int'(cnt_o) == c + 1, "R3 ratio one", int'(cnt_o), c + 1);

        wr(2, 5);
        c = int'(cnt_o); idle(1);
        check(int'(cnt_o) == c + 1, "R5 limit held before update", int'(cnt_o), c + 1);
        wr(4, 1);
        check(cnt_o == 0 && uev_o, "R6 strobe restarts", int'(cnt_o), 0);
        cycles_to_uev(c);
        check(c == 6, "R2 wrap period", c, 6);

        wr(4, 1);                       // realign, cnt 0
        wr(1, 3);
        wr(2, 4);
        cycles_to_uev(c);
        check(c == 4, "R5 old values finish period", c, 4);
        cycles_to_uev(c);
        check(c == 20, "R3 period (P+1)*(L+1)", c, 20);

        wr(0, 0);                       // stop
        c = int'(cnt_o); idle(5);
        check(int'(cnt_o) == c, "R2 hold when stopped", int'(cnt_o), c);
        wr(3, 1);
        check(flag_o == 1, "R9 write one ignored", int'(flag_o), 1);
        check(irq_o == 0, "R10 masked", int'(irq_o), 0);
        wr(0, 8);
        check(irq_o == 1, "R10 enabled", int'(irq_o), 1);
        wr(3, 0);
        check(flag_o == 0 && irq_o == 0, "R9 clear", int'({flag_o, irq_o}), 0);

        wr(0, 3);                       // run + update-off
        wr(1, 0);
        wr(2, 2);
        idle(3);
        wr(4, 1);
        check(cnt_o == 0 && !uev_o, "R7 strobe restarts, no event", int'({cnt_o, uev_o}), 0);
        mx = 0; n_uev = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            if (uev_o) n_uev++;
        end
        check(n_uev == 0 && !flag_o, "R7 no events", n_uev, 0);
        check(mx == 4, "R7 shadow kept", mx, 4);

        wr(0, 5);                       // run + quiet
        wr(4, 1);
        check(uev_o == 1 && flag_o == 0, "R8 quiet strobe", int'({uev_o, flag_o}), 2);
        cycles_to_uev(c);
        check(c == 3, "R5 new values applied", c, 3);
        check(flag_o == 1, "R8 overflow sets flag", int'(flag_o), 1);

        wr(0, 4);                       // quiet, stopped
        wr(3, 0);
        wr(4, 1);
        check(flag_o == 0 && cnt_o == 0, "R8 quiet strobe no flag", int'(flag_o), 0);
        wr(0, 5);
        idle(2);
        wr(4, 1);                       // lands on the overflow edge
        check(uev_o == 1 && flag_o == 1, "R11 coincident sets flag", int'({uev_o, flag_o}), 3);
        idle(1);
        check(uev_o == 0 && cnt_o == 1, "R11 single event", int'({uev_o, cnt_o}), 1);

        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule